// File: doc/BRIEF.md
# Descending Memory Stack Controller

This block runs a last-in, first-out stack kept in one window of a word-addressed synchronous RAM. It owns two registers. The stack pointer holds the address of the item on top. The data register is the only way in and out of the stack: every push takes its word from the data register, and every pop returns its word to it. The stack fills downward. The first item lands at the upper bound of the window, and the last item that fits lands at the lower bound.

To put a word on the stack, the surrounding logic loads it through the data-in port with a load strobe while the controller is idle, then requests a push. To take a word off, it requests a pop and reads the data-register output once `done` pulses. A push lowers the pointer first and then writes. A pop reads first and then raises the pointer. The RAM has one cycle of read latency, so a pop spends one cycle presenting the address and one cycle capturing the data. Two flags report an empty stack and a full stack. A request that would overflow or underflow the stack is dropped and answered with a one-cycle error pulse.

Top module: `mem_stack_ctrl`

## Requirements
- R1: After reset the pointer is one above the upper bound (3002 with the default parameters), `empty`=1, `full`=0, `busy`=0, `done`=0, `err`=0, `mem_we`=0 and `dr_out`=0.
- R2: An accepted push lowers the pointer by one on the accept edge. In the next cycle it drives `mem_we`=1 for exactly one cycle, with `mem_addr` at the new pointer and `mem_wdata` equal to the data register. `done` pulses in the cycle after that write. The first push writes address 3001.
- R3: An accepted pop presents `mem_addr` equal to the pointer, captures `mem_rdata` into the data register one cycle later, and raises the pointer by one on that same edge. `done` pulses in the third cycle after the request is sampled. Pops return words in reverse order of their pushes.
- R4: `empty` is 1 exactly when the pointer is one above the upper bound. `full` is 1 exactly when the pointer equals the lower bound (2000), which happens after 1002 pushes with the defaults.
- R5: A push while `full`, or a pop while `empty`, starts no operation. It writes no memory and leaves the pointer and the data register unchanged. It pulses `err` in the cycle after the request is sampled.
- R6: When `push_req` and `pop_req` are both high in an idle cycle, the push is performed and the pop is dropped.
- R7: While `busy` is 1, push, pop and load requests have no effect.
- R8: `load_en` copies `data_in` into the data register only in an idle cycle that has neither `push_req` nor `pop_req` high.
- R9: `mem_we` is only ever high with `mem_addr` inside the window between the lower and upper bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push request, sampled while idle |
| pop_req | input | 1 | Pop request, sampled while idle |
| load_en | input | 1 | Load strobe for the data register |
| data_in | input | DW (16) | Value to load into the data register |
| dr_out | output | DW (16) | Data register contents |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| err | output | 1 | One-cycle pulse for a dropped overflow or underflow request |
| full | output | 1 | The stack holds its maximum number of items |
| empty | output | 1 | The stack holds no items |
| mem_addr | output | AW (12) | RAM word address |
| mem_wdata | output | DW (16) | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | DW (16) | RAM read data, valid one cycle after the address |

## Verification
The assertions assume the RAM returns, one cycle after an address, the word most recently written there. The bench RAM model does exactly that. They also assume requests are only meaningful while idle. The bench therefore changes requests on falling edges and deliberately holds pop and load high during a push, to check that they are ignored. The reference model is a queue whose depth gives the expected pointer and flags. The bench drives the stack from empty to full and back, so the stimulus reaches both bounds but never leaves the address window.

// File: rtl/mem_stack_ctrl.sv
module mem_stack_ctrl #(
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int TOP_ADDR = 3001,
  parameter int BOT_ADDR = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          load_en,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] dr_out,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);

  localparam logic [AW-1:0] SP_RST = AW'(TOP_ADDR + 1);
  localparam logic [AW-1:0] SP_TOP = AW'(TOP_ADDR);
  localparam logic [AW-1:0] SP_BOT = AW'(BOT_ADDR);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POPA, S_POPC} st_t;

  st_t           state;
  logic [AW-1:0] sp;
  logic [DW-1:0] dr;

  assign busy      = (state != S_IDLE);
  assign full      = (sp == SP_BOT);
  assign empty     = (sp == SP_RST);
  assign mem_addr  = sp;
  assign mem_wdata = dr;
  assign mem_we    = (state == S_PUSH);
  assign dr_out    = dr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sp    <= SP_RST;
      dr    <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (push_req) begin
            if (full) err <= 1'b1;
            else begin
              sp    <= sp - AW'(1);
              state <= S_PUSH;
            end
          end else if (pop_req) begin
            if (empty) err <= 1'b1;
            else state <= S_POPA;
          end else if (load_en) begin
            dr <= data_in;
          end
        end
        S_PUSH: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        S_POPA: state <= S_POPC;
        S_POPC: begin
          dr    <= mem_rdata;
          sp    <= sp + AW'(1);
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R2

  AST_WE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= SP_BOT && mem_addr <= SP_TOP)); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R4

  AST_OVERFLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && push_req && full) |=> (err && !mem_we && !busy)); // R5

  AST_ERR_SP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(sp) && $stable(dr_out))); // R5

  AST_PUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && push_req && pop_req && !full) |=> mem_we); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7

endmodule

// File: tb/mem_stack_ctrl_tb.sv
`timescale 1ns/1ps
module mem_stack_ctrl_tb;
  localparam int AW = 12, DW = 16, TOP = 3001, BOT = 2000;

  logic clk = 0, rst_n = 0;
  logic push_req = 0, pop_req = 0, load_en = 0;
  logic [DW-1:0] data_in = '0, dr_out, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic busy, done, err, full, empty, mem_we;

  always #2.5 clk = ~clk;

  mem_stack_ctrl #(.AW(AW), .DW(DW), .TOP_ADDR(TOP), .BOT_ADDR(BOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .load_en(load_en), .data_in(data_in), .dr_out(dr_out), .busy(busy),
    .done(done), .err(err), .full(full), .empty(empty), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata));

  logic [DW-1:0] ram [0:(1<<AW)-1];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  int n_chk = 0, n_fail = 0;
  int model[$];
  bit track = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int msp();
    return TOP + 1 - model.size();
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // per-clock comparison against the queue model
  always @(negedge clk) begin
    if (rst_n && track) begin
      if (mem_we) chk(mem_addr >= BOT && mem_addr <= TOP, "R9 write in window", int'(mem_addr), TOP);
      if (!busy && !done) begin
        chk(empty == (model.size() == 0), "R4 empty flag", int'(empty), int'(model.size() == 0));
        chk(full == (msp() == BOT), "R4 full flag", int'(full), int'(msp() == BOT));
      end
    end
  end

  task automatic load(input logic [DW-1:0] v);
    @(negedge clk); load_en = 1; data_in = v;
    @(negedge clk); load_en = 0;
    chk(dr_out == v, "R8 idle load", int'(dr_out), int'(v));
  endtask

  task automatic push_op(input bit with_pop, input bit with_load);
    logic [DW-1:0] old = dr_out;
    int exp_addr = msp() - 1;
    @(negedge clk); push_req = 1; pop_req = with_pop; load_en = with_load; data_in = ~old;
    @(negedge clk); push_req = 0; pop_req = 0; load_en = 0;
    chk(mem_we == 1 && int'(mem_addr) == exp_addr, "R2 write cycle addr", int'(mem_addr), exp_addr);
    chk(mem_wdata == old, "R2/R8 write data from data register", int'(mem_wdata), int'(old));
    @(negedge clk);
    chk(done == 1 && mem_we == 0, "R2 done after one write", int'(done), 1);
    chk(ram[exp_addr] == old, "R2 memory holds pushed word", int'(ram[exp_addr]), int'(old));
    chk(dr_out == old, "R8 data register unchanged by push", int'(dr_out), int'(old));
    model.push_back(int'(old));
  endtask

  task automatic pop_op();
    int exp = model[model.size()-1];
    @(negedge clk); pop_req = 1;
    @(negedge clk); pop_req = 0;
    chk(int'(mem_addr) == msp(), "R3 pop address", int'(mem_addr), msp());
    @(negedge clk);
    chk(done == 0 && busy == 1, "R3 capture cycle", int'(done), 0);
    @(negedge clk);
    chk(done == 1, "R3 done latency", int'(done), 1);
    chk(int'(dr_out) == exp, "R3 LIFO order", int'(dr_out), exp);
    void'(model.pop_back());
    chk(int'(mem_addr) == msp(), "R3 pointer raised", int'(mem_addr), msp());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(empty == 1 && full == 0 && busy == 0 && done == 0 && err == 0 && mem_we == 0,
        "R1 reset flags", int'({empty, full, busy, done, err, mem_we}), 6'b100000);
    chk(int'(mem_addr) == TOP + 1, "R1 reset pointer", int'(mem_addr), TOP + 1);
    chk(dr_out == 0, "R1 reset data register", int'(dr_out), 0);
    rst_n = 1;
    @(negedge clk); track = 1;

    // R5: pop while empty
    load(16'h1234);
    @(negedge clk); pop_req = 1;
    @(negedge clk); pop_req = 0;
    chk(err == 1 && busy == 0 && mem_we == 0, "R5 underflow err", int'(err), 1);
    chk(dr_out == 16'h1234, "R5 underflow keeps data register", int'(dr_out), 32'h1234);
    @(negedge clk);
    chk(err == 0, "R5 err one cycle", int'(err), 0);

    // R2/R3 basic pattern
    push_op(0, 0);
    chk(mem_addr == TOP, "R2 first item at upper bound", int'(mem_addr), TOP);
    load(16'hBEEF); push_op(0, 0);
    load(16'h00F0); push_op(0, 0);
    pop_op(); pop_op();

    // R6: simultaneous push and pop
    load(16'hA5A5); push_op(1, 0);
    chk(model.size() == 2, "R6 push wins", model.size(), 2);

    // R8: load with a request is dropped
    load(16'h0707); push_op(0, 1);

    // R7: requests during busy ignored
    load(16'h3C3C);
    @(negedge clk); push_req = 1;
    @(negedge clk); push_req = 0; pop_req = 1; load_en = 1; data_in = 16'hFFFF;
    @(negedge clk); pop_req = 0; load_en = 0;
    chk(done == 1, "R7 push completes", int'(done), 1);
    model.push_back(32'h3C3C);
    @(negedge clk);
    chk(busy == 0 && dr_out == 16'h3C3C, "R7 no pop or load while busy", int'(dr_out), 32'h3C3C);
    while (model.size() > 0) pop_op();

    // R4/R5: fill to the lower bound
    for (int i = 0; i < TOP - BOT + 1; i++) begin
      load(16'(i ^ 16'h5A5A)); push_op(0, 0);
    end
    chk(full == 1 && int'(mem_addr) == BOT, "R4 full at lower bound", int'(mem_addr), BOT);
    load(16'h9999);
    @(negedge clk); push_req = 1;
    @(negedge clk); push_req = 0;
    chk(err == 1 && mem_we == 0 && busy == 0, "R5 overflow dropped", int'(err), 1);
    chk(ram[BOT-1] !== 16'h9999, "R5 no write below window", int'(ram[BOT-1]), 0);
    @(negedge clk);
    chk(full == 1 && int'(mem_addr) == BOT, "R5 pointer kept", int'(mem_addr), BOT);
    while (model.size() > 0) pop_op();
    chk(empty == 1, "R4 empty after drain", int'(empty), 1);

    finish_up();
  end
endmodule